// File: doc/BRIEF.md
# ECC Memory Write Path Controller

This block sits between a processor's load/store request port and a 64-bit memory that stores an 8-bit check byte beside every word. It protects stored data with a (72,64) Hamming SEC-DED code. A full 64-bit store is encoded and written in a single memory access. A narrower store is normally done as a read-modify-write: the containing word is read, checked and corrected, the new bytes are merged in, and the word is written back with a fresh check byte.

Two configuration registers set the mode. The bus control register holds the ECC enable bit. The ECC test register holds a write-only bypass bit. When bypass is set and ECC is on, narrow stores skip the read phase and are written once, with a check byte that matches the whole driven word. Loads are still checked and corrected. The bypass bit can only change while ECC is off. An attempt to change it with ECC on is dropped and flagged. With ECC off, every store is a single write and loads return the raw word.

Top module: `ecc_wr_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_req` are 0, and both configuration registers read as 0.
- R2: A store with all eight byte enables set makes exactly one memory write and no memory read. `mem_req`, `mem_we` and `mem_addr` stay unchanged until `mem_ack`. A later load returns the stored word with no error flags.
- R3: With ECC on and bypass clear, a store with some byte enables clear makes one memory read, then one memory write. Enable bit i selects data bits [8i+7:8i] from the request and the other bytes from the old word. A single-bit error in the old word is corrected before the merge.
- R4: With ECC on and bypass set, a narrow store makes one memory write, of the request word unchanged, and no read. A later checked load of that word reports no error.
- R5: Register select 0 is bus control, with ECC enable at bit 3, readable. Register select 1 holds bypass at bit 31; it is write-only and reads as 0. A write to select 1 while ECC is enabled leaves bypass unchanged and raises `cfg_reject` for one cycle. With ECC disabled, `cfg_reject` stays 0.
- R6: With ECC on, a load whose word or check byte has one flipped bit returns the corrected word with `resp_corrected` = 1 and `resp_uncorr` = 0.
- R7: With ECC on, a load with two flipped data bits returns `resp_uncorr` = 1. `resp_corrected` and `resp_uncorr` are never both 1.
- R8: If the read phase of a read-modify-write finds an uncorrectable word, the merged word is still written back, and that store's response has `resp_uncorr` = 1.
- R9: With ECC off, every store is a single write with check byte 0. A load returns the raw memory word with both error flags at 0.
- R10: `req_ready` drops in the cycle after a request is accepted and stays low until the response. `resp_valid` lasts exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Register select: 0 bus control, 1 ECC test |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| cfg_reject | output | 1 | One-cycle pulse: bypass write refused |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_we | input | 1 | 1 store, 0 load |
| req_addr | input | AW | 64-bit word address |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Byte enables, bit i for byte i |
| resp_valid | output | 1 | Response strobe, one per request |
| resp_rdata | output | 64 | Load data (0 for stores) |
| resp_corrected | output | 1 | Load had a corrected single-bit error |
| resp_uncorr | output | 1 | Uncorrectable error on load or on the RMW read |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_wcheck | output | 8 | Memory write check byte |
| mem_ack | input | 1 | Memory completes the access |
| mem_rdata | input | 64 | Memory read data, valid with ack |
| mem_rcheck | input | 8 | Memory read check byte, valid with ack |

## Verification
Stores are issued with all enables set, with the low half, with a single low byte, and with only the top byte. Counting memory reads and writes per request separates the direct-write path from the read-modify-write path, and a follow-up load shows which bytes were merged. Faults are injected into the read return path: one data bit, one check bit, and two data bits. These separate correction from detection, and an injection during the read phase of a merge shows correction before merge (R3) or write-back despite an uncorrectable word (R8). The bypass mode is tried both with a refused write and with an accepted one, so the path count shows whether the bit changed.

// File: rtl/ecc_wr_pkg.sv
// Shared types and the (72,64) SEC-DED code used by the write-path controller.
// Assumes a 64-bit word and an 8-bit check byte; bit 7 is overall parity.
package ecc_wr_pkg;

    localparam int DW = 64;
    localparam int CW = 8;
    localparam int BW = DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_MERGE, ST_WR_REQ, ST_WR_WAIT, ST_DONE
    } wr_state_e;

    // Codeword position (3..71, skipping powers of two) of data bit idx.
    function automatic logic [6:0] data_pos(input int idx);
        int cnt;
        logic [6:0] p;
        cnt = 0;
        p   = '0;
        for (int pos = 3; pos < 72; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                if (cnt == idx) p = pos[6:0];
                cnt++;
            end
        end
        return p;
    endfunction

    // Check byte: bits 6..0 Hamming parity, bit 7 parity over all 71 others.
    function automatic logic [CW-1:0] secded_check(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        logic [6:0]    p;
        c = '0;
        for (int i = 0; i < DW; i++) begin
            p = data_pos(i);
            for (int k = 0; k < 7; k++) begin
                if (p[k]) c[k] = c[k] ^ d[i];
            end
        end
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

endpackage

// File: rtl/ecc_cfg_regs.sv
// Configuration registers: ECC enable (select 0, bit 3) and the write-only
// store bypass bit (select 1, bit 31). Bypass may change only while ECC is
// off; a refused write raises a one-cycle reject pulse.
module ecc_cfg_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        cfg_reject,
    output logic        ecc_en,
    output logic        bypass
);

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[30:4], cfg_wdata[2:0]};

    // Register updates, with the bypass lock while ECC is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_en     <= 1'b0;
            bypass     <= 1'b0;
            cfg_reject <= 1'b0;
        end else begin
            cfg_reject <= 1'b0;
            if (cfg_wr && !cfg_sel) ecc_en <= cfg_wdata[3];
            if (cfg_wr && cfg_sel) begin
                if (ecc_en) cfg_reject <= 1'b1;
                else        bypass     <= cfg_wdata[31];
            end
        end
    end

    // Read mux; the bypass register never returns its contents.
    always_comb begin
        cfg_rdata = '0;
        if (!cfg_sel) cfg_rdata[3] = ecc_en;
    end

    a_r5_bypass_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel && ecc_en) |=> ($stable(bypass) && cfg_reject));

    a_r5_no_reject_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel && !ecc_en) |=> !cfg_reject);

endmodule

// File: rtl/ecc_secded_dec.sv
// Combinational SEC-DED decoder for a captured 72-bit codeword. It corrects
// one flipped bit and flags two; a syndrome outside the codeword counts as
// uncorrectable.
module ecc_secded_dec
    import ecc_wr_pkg::*;
(
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] cin,
    output logic [DW-1:0] dout,
    output logic          corrected,
    output logic          uncorr
);

    logic [CW-1:0] recalc;
    logic [6:0]    syn;
    logic          par_all;
    logic          hit;

    // Syndrome, overall parity and single-bit repair.
    always_comb begin
        recalc    = secded_check(din);
        syn       = recalc[6:0] ^ cin[6:0];
        par_all   = (^din) ^ (^cin);
        dout      = din;
        corrected = 1'b0;
        uncorr    = 1'b0;
        hit       = 1'b0;
        if (par_all) begin
            if (syn == '0 || $countones(syn) == 1) begin
                corrected = 1'b1;
            end else begin
                for (int i = 0; i < DW; i++) begin
                    if (data_pos(i) == syn) begin
                        dout[i] = ~din[i];
                        hit     = 1'b1;
                    end
                end
                corrected = hit;
                uncorr    = !hit;
            end
        end else if (syn != '0) begin
            uncorr = 1'b1;
        end
    end

    // R7: a word is never both repaired and flagged uncorrectable.
    always_comb begin
        a_r7_flags_exclusive: assert (!(corrected && uncorr));
    end

endmodule

// File: rtl/ecc_wr_fsm.sv
// Request sequencer: picks single write, read-modify-write or read per
// request, runs the memory handshake (request held until ack), merges bytes
// and builds the response. The mode bits are sampled when a request is
// accepted. Assumes one request in flight.
module ecc_wr_fsm
    import ecc_wr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ecc_en,
    input  logic          bypass,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [BW-1:0] req_be,
    output logic          resp_valid,
    output logic [DW-1:0] resp_rdata,
    output logic          resp_corrected,
    output logic          resp_uncorr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [CW-1:0] mem_wcheck,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic [CW-1:0] mem_rcheck,
    output logic [DW-1:0] cap_data,
    output logic [CW-1:0] cap_check,
    input  logic [DW-1:0] dec_data,
    input  logic          dec_corr,
    input  logic          dec_uncorr
);

    wr_state_e     state;
    logic          op_we;
    logic          op_ecc;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_wdata;
    logic [BW-1:0] op_be;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] wr_check;
    logic          rmw_bad;
    logic [DW-1:0] merged;
    logic          direct_wr;

    // Byte merge of new store data over the corrected old word.
    always_comb begin
        for (int b = 0; b < BW; b++) begin
            merged[8*b +: 8] = op_be[b] ? op_wdata[8*b +: 8] : dec_data[8*b +: 8];
        end
    end

    assign direct_wr = (req_be == '1) || !ecc_en || bypass;

    // Sequencer state and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_we     <= 1'b0;
            op_ecc    <= 1'b0;
            op_addr   <= '0;
            op_wdata  <= '0;
            op_be     <= '0;
            wr_data   <= '0;
            wr_check  <= '0;
            rmw_bad   <= 1'b0;
            cap_data  <= '0;
            cap_check <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    op_we    <= req_we;
                    op_ecc   <= ecc_en;
                    op_addr  <= req_addr;
                    op_wdata <= req_wdata;
                    op_be    <= req_be;
                    wr_data  <= req_wdata;
                    rmw_bad  <= 1'b0;
                    state    <= (req_we && direct_wr) ? ST_WR_REQ : ST_RD_REQ;
                end
                ST_RD_REQ:  state <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_ack) begin
                    cap_data  <= mem_rdata;
                    cap_check <= mem_rcheck;
                    state     <= op_we ? ST_MERGE : ST_DONE;
                end
                ST_MERGE: begin
                    wr_data <= merged;
                    rmw_bad <= dec_uncorr;
                    state   <= ST_WR_REQ;
                end
                ST_WR_REQ: begin
                    wr_check <= op_ecc ? secded_check(wr_data) : '0;
                    state    <= ST_WR_WAIT;
                end
                ST_WR_WAIT: if (mem_ack) state <= ST_DONE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Port views of the sequencer state.
    assign req_ready      = (state == ST_IDLE);
    assign mem_req        = (state == ST_RD_WAIT) || (state == ST_WR_WAIT);
    assign mem_we         = (state == ST_WR_WAIT);
    assign mem_addr       = op_addr;
    assign mem_wdata      = wr_data;
    assign mem_wcheck     = wr_check;
    assign resp_valid     = (state == ST_DONE);
    assign resp_rdata     = op_we ? '0 : (op_ecc ? dec_data : cap_data);
    assign resp_corrected = !op_we && op_ecc && dec_corr;
    assign resp_uncorr    = op_we ? rmw_bad : (op_ecc && dec_uncorr);

    a_r10_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r10_resp_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r2_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r9_zero_check: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !op_ecc) |-> (mem_wcheck == '0));

endmodule

// File: rtl/ecc_wr_ctrl.sv
// Top of the ECC memory write path: configuration registers, request
// sequencer and SEC-DED decoder on the captured read word.
module ecc_wr_ctrl
    import ecc_wr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          cfg_reject,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [63:0]   req_wdata,
    input  logic [7:0]    req_be,
    output logic          resp_valid,
    output logic [63:0]   resp_rdata,
    output logic          resp_corrected,
    output logic          resp_uncorr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [63:0]   mem_wdata,
    output logic [7:0]    mem_wcheck,
    input  logic          mem_ack,
    input  logic [63:0]   mem_rdata,
    input  logic [7:0]    mem_rcheck
);

    logic          ecc_en;
    logic          bypass;
    logic [DW-1:0] cap_data;
    logic [CW-1:0] cap_check;
    logic [DW-1:0] dec_data;
    logic          dec_corr;
    logic          dec_uncorr;

    ecc_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_reject (cfg_reject),
        .ecc_en     (ecc_en),
        .bypass     (bypass)
    );

    ecc_secded_dec u_dec (
        .din       (cap_data),
        .cin       (cap_check),
        .dout      (dec_data),
        .corrected (dec_corr),
        .uncorr    (dec_uncorr)
    );

    ecc_wr_fsm #(.AW(AW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ecc_en         (ecc_en),
        .bypass         (bypass),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_we         (req_we),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .req_be         (req_be),
        .resp_valid     (resp_valid),
        .resp_rdata     (resp_rdata),
        .resp_corrected (resp_corrected),
        .resp_uncorr    (resp_uncorr),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_wcheck     (mem_wcheck),
        .mem_ack        (mem_ack),
        .mem_rdata      (mem_rdata),
        .mem_rcheck     (mem_rcheck),
        .cap_data       (cap_data),
        .cap_check      (cap_check),
        .dec_data       (dec_data),
        .dec_corr       (dec_corr),
        .dec_uncorr     (dec_uncorr)
    );

endmodule

// File: tb/ecc_wr_ctrl_tb.sv
// Scoreboard bench: the driver task queues the expected response of each
// request; a monitor pops and compares on every resp_valid. A memory model
// with a fault-injection mask on its read path counts reads and writes.
`timescale 1ns/1ps
module ecc_wr_ctrl_tb;

    localparam int AW = 10;

    typedef struct {
        bit          is_rd;
        logic [63:0] data;
        bit          corr;
        bit          unc;
        bit          cmp_data;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          cfg_reject;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic [7:0]    req_be = '0;
    logic          resp_valid;
    logic [63:0]   resp_rdata;
    logic          resp_corrected;
    logic          resp_uncorr;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [7:0]    mem_wcheck;
    logic          mem_ack;
    logic [63:0]   mem_rdata;
    logic [7:0]    mem_rcheck;

    logic [63:0] md [16];
    logic [7:0]  mc [16];
    logic [1:0]  dly;
    int          rd_cnt, wr_cnt, resp_cnt;
    logic [63:0] inj_data = '0;
    logic [7:0]  inj_chk = '0;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;
    exp_t        sb[$];

    always #2.5 clk = ~clk;

    ecc_wr_ctrl #(.AW(AW)) u_dut (.*);

    // Memory model: ack two cycles into a request, faults applied on reads.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; dly <= '0; rd_cnt <= 0; wr_cnt <= 0;
            mem_rdata <= '0; mem_rcheck <= '0;
            for (int i = 0; i < 16; i++) begin md[i] <= '0; mc[i] <= '0; end
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (dly == 2'd1) begin
                mem_ack <= 1'b1; dly <= '0;
                if (mem_we) begin
                    md[mem_addr[3:0]] <= mem_wdata;
                    mc[mem_addr[3:0]] <= mem_wcheck;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata  <= md[mem_addr[3:0]] ^ inj_data;
                    mem_rcheck <= mc[mem_addr[3:0]] ^ inj_chk;
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                dly <= dly + 2'd1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10", "unexpected response", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.is_rd && e.cmp_data)
                    chk(resp_rdata == e.data, e.tag, "rdata", resp_rdata, e.data);
                chk(resp_corrected == e.corr, e.tag, "corrected", 64'(resp_corrected), 64'(e.corr));
                chk(resp_uncorr == e.unc, e.tag, "uncorr", 64'(resp_uncorr), 64'(e.unc));
            end
            resp_cnt++;
        end
    end

    task automatic cfg_write(input bit sel, input logic [31:0] d, input bit exp_rej, input string tag);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
        chk(cfg_reject == exp_rej, tag, "cfg_reject", 64'(cfg_reject), 64'(exp_rej));
    endtask

    task automatic cfg_read(input bit sel, input logic [31:0] exp, input string tag);
        @(negedge clk); cfg_sel = sel;
        #1 chk(cfg_rdata == exp, tag, "cfg_rdata", 64'(cfg_rdata), 64'(exp));
    endtask

    // Driver: queue expectation, issue one request, wait for its response.
    task automatic do_req(input bit we, input int addr, input logic [63:0] d,
                          input logic [7:0] be, input logic [63:0] exp_d,
                          input bit cmp, input bit ec, input bit eu,
                          input int exp_rd, input int exp_wr, input string tag);
        int rd0, wr0, n0, wd;
        exp_t e;
        e.is_rd = !we; e.data = exp_d; e.corr = ec; e.unc = eu; e.cmp_data = cmp; e.tag = tag;
        sb.push_back(e);
        rd0 = rd_cnt; wr0 = wr_cnt; n0 = resp_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R10", "ready after accept", 64'(req_ready), 64'd0);
        wd = 0;
        while (resp_cnt == n0 && wd < 200) begin @(negedge clk); wd++; end
        chk(resp_cnt == n0 + 1, tag, "response count", 64'(resp_cnt - n0), 64'd1);
        chk(rd_cnt - rd0 == exp_rd, tag, "mem reads", 64'(rd_cnt - rd0), 64'(exp_rd));
        chk(wr_cnt - wr0 == exp_wr, tag, "mem writes", 64'(wr_cnt - wr0), 64'(exp_wr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R1", "resp_valid", 64'(resp_valid), 64'd0);
        chk(mem_req == 1'b0, "R1", "mem_req", 64'(mem_req), 64'd0);
        cfg_read(1'b0, 32'h0, "R1");
        cfg_read(1'b1, 32'h0, "R1");

        cfg_write(1'b0, 32'h8, 1'b0, "R5");
        cfg_read(1'b0, 32'h8, "R5");

        // R2: full store, then load
        do_req(1, 1, 64'h0123_4567_89AB_CDEF, 8'hFF, '0, 0, 0, 0, 0, 1, "R2");
        do_req(0, 1, '0, 8'h00, 64'h0123_4567_89AB_CDEF, 1, 0, 0, 1, 0, "R2");

        // R3: low half merge, then single byte merge over a corrupted old word
        do_req(1, 1, 64'hFFFF_FFFF_1111_2222, 8'h0F, '0, 0, 0, 0, 1, 1, "R3");
        do_req(0, 1, '0, 8'h00, 64'h0123_4567_1111_2222, 1, 0, 0, 1, 0, "R3");
        inj_data = 64'h1 << 40;
        do_req(1, 1, 64'h5555_5555_5555_55AA, 8'h01, '0, 0, 0, 0, 1, 1, "R3");
        inj_data = '0;
        do_req(0, 1, '0, 8'h00, 64'h0123_4567_1111_22AA, 1, 0, 0, 1, 0, "R3");

        // R6: single data bit and single check bit flips on load
        inj_data = 64'h20;
        do_req(0, 1, '0, 8'h00, 64'h0123_4567_1111_22AA, 1, 1, 0, 1, 0, "R6");
        inj_data = '0; inj_chk = 8'h04;
        do_req(0, 1, '0, 8'h00, 64'h0123_4567_1111_22AA, 1, 1, 0, 1, 0, "R6");
        inj_chk = '0;

        // R7: double data bit flip
        inj_data = 64'h3;
        do_req(0, 1, '0, 8'h00, '0, 0, 0, 1, 1, 0, "R7");
        inj_data = '0;

        // R8: uncorrectable read phase still writes back the merged word
        do_req(1, 2, 64'hAAAA_5555_0F0F_F0F0, 8'hFF, '0, 0, 0, 0, 0, 1, "R8");
        inj_data = 64'h3;
        do_req(1, 2, 64'h7700_0000_0000_0000, 8'h80, '0, 0, 0, 1, 1, 1, "R8");
        inj_data = '0;
        do_req(0, 2, '0, 8'h00, 64'h77AA_5555_0F0F_F0F3, 1, 0, 0, 1, 0, "R8");

        // R5: bypass write refused while ECC is on, store still does RMW
        do_req(1, 3, 64'h1111_2222_3333_4444, 8'hFF, '0, 0, 0, 0, 0, 1, "R5");
        cfg_write(1'b1, 32'h8000_0000, 1'b1, "R5");
        do_req(1, 3, 64'h0000_0000_0000_0099, 8'h01, '0, 0, 0, 0, 1, 1, "R5");
        cfg_read(1'b1, 32'h0, "R5");

        // R4: bypass accepted with ECC off, then narrow store is one write
        cfg_write(1'b0, 32'h0, 1'b0, "R4");
        cfg_write(1'b1, 32'h8000_0000, 1'b0, "R5");
        cfg_write(1'b0, 32'h8, 1'b0, "R4");
        do_req(1, 3, 64'hDEAD_BEEF_0000_BB00, 8'h02, '0, 0, 0, 0, 0, 1, "R4");
        do_req(0, 3, '0, 8'h00, 64'hDEAD_BEEF_0000_BB00, 1, 0, 0, 1, 0, "R4");

        // R9: ECC off, single writes with zero check, raw loads
        cfg_write(1'b0, 32'h0, 1'b0, "R9");
        do_req(1, 4, 64'hCAFE_F00D_1234_5678, 8'hFF, '0, 0, 0, 0, 0, 1, "R9");
        chk(mc[4] == 8'h00, "R9", "stored check", 64'(mc[4]), 64'd0);
        do_req(1, 4, 64'h0000_0000_0000_00EE, 8'h01, '0, 0, 0, 0, 0, 1, "R9");
        inj_data = 64'h1; inj_chk = 8'hFF;
        do_req(0, 4, '0, 8'h00, 64'h0000_0000_0000_00EF, 1, 0, 0, 1, 0, "R9");
        inj_data = '0; inj_chk = '0;

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R10", "scoreboard drained", 64'(sb.size()), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "R10", "watchdog expired", 64'd1, 64'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule